// File: doc/BRIEF.md
# Bulk Write Packet Framer

This block turns one bulk write payload into the byte stream a serial peripheral expects once the matching write command has been accepted. A single start strobe supplies the total byte count and latches whether the link runs with checksum trailers. The framer then pulls payload bytes from an upstream valid/ready stream and pushes a framed byte stream downstream, also under valid/ready flow control.

The payload is cut into packets that hold at most `MAX_PKT` bytes. Each packet opens with one header byte. The upper nibble of that byte is all ones. The lower two bits tell the receiver where the packet sits in the transfer. When trailers are enabled, two zero bytes close each packet. A transfer of `MIN_LEN` bytes or fewer does not belong on this path. It is refused with a one-cycle reject pulse and produces no output. A one-cycle done pulse marks the end of a transfer that was accepted.

Top module: `blkwr_framer`

## Requirements
- R1: Each header byte equals 0xF0 with a 2-bit position code in bits 1:0. The code is 3 whenever the bytes still to send fit in one packet (remaining <= MAX_PKT).
- R2: When the remaining count exceeds MAX_PKT at the first packet of a transfer, that header carries code 1.
- R3: Packets after the first that do not finish the transfer carry code 2. The final packet of a multi-packet transfer carries code 3.
- R4: Each packet carries min(remaining, MAX_PKT) payload bytes. The remaining count drops by that amount after each packet, and framing stops when it reaches zero.
- R5: With trailers enabled at start, each packet's payload is followed by exactly two 0x00 bytes. With trailers disabled, nothing is appended. Changing the trailer input after start has no effect on the running transfer.
- R6: Payload bytes leave in arrival order and unmodified. The upstream ready is raised only while payload is being passed. Exactly the requested number of bytes is consumed.
- R7: While the output is valid and not accepted, the output stays valid and its byte is unchanged.
- R8: doneOut pulses high for exactly one cycle, in the cycle after the handshake of the transfer's last output byte.
- R9: A start with a count of MIN_LEN or less is refused. rejectOut pulses in the next cycle, and the block emits no byte and consumes none.
- R10: A start strobe that arrives during a running transfer is ignored.
- R11: After reset, outValid, inReady, doneOut and rejectOut are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle strobe that starts a transfer |
| lenIn | input | LEN_W | Total payload byte count, sampled with startIn |
| crcEnIn | input | 1 | Trailer enable, sampled with startIn |
| inData | input | 8 | Upstream payload byte |
| inValid | input | 1 | Upstream byte valid |
| inReady | output | 1 | Block accepts the upstream byte |
| outData | output | 8 | Framed output byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the output byte |
| doneOut | output | 1 | Transfer finished pulse |
| rejectOut | output | 1 | Start refused (count too small) pulse |

## Verification
The bench builds the framer with MAX_PKT = 8, LEN_W = 16 and MIN_LEN = 4. The small packet cap means transfers of 9 to 20 bytes already produce first, middle and final headers. They also cover an exact-fit packet and the trailer placed after every packet, all within a few dozen cycles. The same widths let the bench place counts on both sides of the rejection limit and apply downstream stalls and upstream gaps in every packet phase.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;
  typedef enum logic [1:0] {SEL_ZERO, SEL_HDR, SEL_PAY} outSel_e;

  typedef struct packed {
    logic    load;
    logic    hdrTake;
    logic    byteTake;
    outSel_e sel;
  } dpCtrl_t;

  localparam logic [3:0] HDR_TAG   = 4'hF;
  localparam logic [1:0] ORD_FIRST = 2'd1;
  localparam logic [1:0] ORD_MID   = 2'd2;
  localparam logic [1:0] ORD_ONLY  = 2'd3;
endpackage

// File: rtl/blkwr_datapath.sv
module blkwr_datapath
  import blkwr_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int MAX_PKT = 8192,
  parameter int MIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [LEN_W-1:0] lenIn,
  input  logic [7:0]       inData,
  output logic [7:0]       outData,
  output logic             tooShort,
  output logic             pktLast,
  output logic             remOne,
  output logic             remZero
);
  localparam int PKT_W = $clog2(MAX_PKT + 1);
  localparam logic [LEN_W:0]   MAX_EXT = (LEN_W + 1)'(MAX_PKT);
  localparam logic [LEN_W-1:0] MIN_EXT = LEN_W'(MIN_LEN);
  localparam logic [PKT_W-1:0] PKT_CAP = PKT_W'(MAX_PKT);

  logic [LEN_W-1:0] remaining;
  logic [PKT_W-1:0] pktLeft;
  logic             firstPkt;
  logic             fitsOne;
  logic [PKT_W-1:0] pktLen;
  logic [1:0]       ordCode;

  assign fitsOne = {1'b0, remaining} <= MAX_EXT;
  assign pktLen  = fitsOne ? remaining[PKT_W-1:0] : PKT_CAP;
  assign ordCode = fitsOne ? ORD_ONLY : (firstPkt ? ORD_FIRST : ORD_MID);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      pktLeft   <= '0;
      firstPkt  <= 1'b0;
    end else if (ctrl.load) begin
      remaining <= lenIn;
      firstPkt  <= 1'b1;
    end else if (ctrl.hdrTake) begin
      pktLeft  <= pktLen;
      firstPkt <= 1'b0;
    end else if (ctrl.byteTake) begin
      remaining <= remaining - 1'b1;
      pktLeft   <= pktLeft - 1'b1;
    end
  end

  always_comb begin
    unique case (ctrl.sel)
      SEL_HDR: outData = {HDR_TAG, 2'b00, ordCode};
      SEL_PAY: outData = inData;
      default: outData = 8'h00;
    endcase
  end

  assign tooShort = lenIn <= MIN_EXT;
  assign pktLast  = pktLeft == PKT_W'(1);
  assign remOne   = remaining == LEN_W'(1);
  assign remZero  = remaining == '0;
endmodule

// File: rtl/blkwr_ctrl.sv
module blkwr_ctrl
  import blkwr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    crcEnIn,
  input  logic    inValid,
  input  logic    outReady,
  input  logic    tooShort,
  input  logic    pktLast,
  input  logic    remOne,
  input  logic    remZero,
  output dpCtrl_t ctrl,
  output logic    outValid,
  output logic    inReady,
  output logic    doneOut,
  output logic    rejectOut,
  output logic    busy
);
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PAY, ST_CRC0, ST_CRC1, ST_FIN} state_e;

  state_e state, stateNext;
  logic   crcOn;
  logic   rejectQ;

  always_comb begin
    ctrl      = '0;
    ctrl.sel  = SEL_ZERO;
    outValid  = 1'b0;
    inReady   = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        ctrl.load = startIn && !tooShort;
        if (startIn && !tooShort) stateNext = ST_HDR;
      end
      ST_HDR: begin
        ctrl.sel     = SEL_HDR;
        outValid     = 1'b1;
        ctrl.hdrTake = outReady;
        if (outReady) stateNext = ST_PAY;
      end
      ST_PAY: begin
        ctrl.sel      = SEL_PAY;
        outValid      = inValid;
        inReady       = outReady;
        ctrl.byteTake = inValid && outReady;
        if (inValid && outReady && pktLast)
          stateNext = crcOn ? ST_CRC0 : (remOne ? ST_FIN : ST_HDR);
      end
      ST_CRC0: begin
        outValid = 1'b1;
        if (outReady) stateNext = ST_CRC1;
      end
      ST_CRC1: begin
        outValid = 1'b1;
        if (outReady) stateNext = remZero ? ST_FIN : ST_HDR;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      crcOn   <= 1'b0;
      rejectQ <= 1'b0;
    end else begin
      state   <= stateNext;
      rejectQ <= (state == ST_IDLE) && startIn && tooShort;
      if (ctrl.load) crcOn <= crcEnIn;
    end
  end

  assign doneOut   = state == ST_FIN;
  assign rejectOut = rejectQ;
  assign busy      = state != ST_IDLE;
endmodule

// File: rtl/blkwr_framer.sv
module blkwr_framer
  import blkwr_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int MAX_PKT = 8192,
  parameter int MIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             crcEnIn,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             doneOut,
  output logic             rejectOut
);
  dpCtrl_t ctrl;
  logic    tooShort, pktLast, remOne, remZero, busy;

  blkwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .crcEnIn(crcEnIn),
    .inValid(inValid), .outReady(outReady), .tooShort(tooShort),
    .pktLast(pktLast), .remOne(remOne), .remZero(remZero), .ctrl(ctrl),
    .outValid(outValid), .inReady(inReady), .doneOut(doneOut),
    .rejectOut(rejectOut), .busy(busy)
  );

  blkwr_datapath #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT), .MIN_LEN(MIN_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .lenIn(lenIn), .inData(inData),
    .outData(outData), .tooShort(tooShort), .pktLast(pktLast),
    .remOne(remOne), .remZero(remZero)
  );
endmodule

// File: rtl/blkwr_checker.sv
module blkwr_checker #(
  parameter int LEN_W   = 24,
  parameter int MIN_LEN = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [LEN_W-1:0] lenIn,
  input logic [7:0]       inData,
  input logic             inValid,
  input logic             inReady,
  input logic [7:0]       outData,
  input logic             outValid,
  input logic             outReady,
  input logic             doneOut,
  input logic             rejectOut,
  input logic             busy
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData)); // R7
  AST_PAY_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |-> outValid && outData == inData); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R8
  AST_REJECT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startIn && lenIn <= LEN_W'(MIN_LEN) |=> rejectOut && !outValid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid && !inReady); // R11
endmodule

bind blkwr_framer blkwr_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .lenIn(lenIn), .inData(inData),
  .inValid(inValid), .inReady(inReady), .outData(outData), .outValid(outValid),
  .outReady(outReady), .doneOut(doneOut), .rejectOut(rejectOut), .busy(busy)
);

// File: tb/blkwr_framer_bench.sv
module blkwr_framer_bench;
  localparam int LEN_W = 16;
  localparam int MAXP  = 8;
  localparam int MINL  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startIn = 1'b0;
  logic [LEN_W-1:0] lenIn = '0;
  logic             crcEnIn = 1'b0;
  logic [7:0]       inData = '0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [7:0]       outData;
  logic             outValid;
  logic             outReady = 1'b1;
  logic             doneOut;
  logic             rejectOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  blkwr_framer #(.LEN_W(LEN_W), .MAX_PKT(MAXP), .MIN_LEN(MINL)) u_blkwr_framer (
    .clk(clk), .rstN(rstN), .startIn(startIn), .lenIn(lenIn), .crcEnIn(crcEnIn),
    .inData(inData), .inValid(inValid), .inReady(inReady), .outData(outData),
    .outValid(outValid), .outReady(outReady), .doneOut(doneOut), .rejectOut(rejectOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] srcByte(input int k, input int len);
    return 8'((k * 37 + len * 5 + 3) & 255);
  endfunction

  task automatic runXfer(input int len, input bit crc, input bit stall, input bit gaps,
                         input bit poke, input string tag);
    logic [7:0] expB[0:511];
    logic [7:0] got[0:511];
    int expN = 0, capN = 0, srcIdx = 0, lastCap = -1, doneCyc = -100, doneCnt = 0;
    int holdErr = 0, rejSeen = 0, rem = len, idx = 0, bad = 0;
    bit first = 1, pending = 0, prevHeld = 0;
    logic [7:0] prevData = '0;
    while (rem > 0) begin
      int n = (rem <= MAXP) ? rem : MAXP;
      logic [1:0] code = (rem <= MAXP) ? 2'd3 : (first ? 2'd1 : 2'd2);
      expB[expN++] = 8'hF0 | {6'd0, code};
      for (int i = 0; i < n; i++) expB[expN++] = srcByte(idx++, len);
      if (crc) begin expB[expN++] = 8'h00; expB[expN++] = 8'h00; end
      rem -= n;
      first = 0;
    end
    @(negedge clk);
    startIn = 1'b1; lenIn = LEN_W'(len); crcEnIn = crc;
    for (int cyc = 0; cyc < 3000 && !(doneCnt > 0 && cyc > doneCyc + 3); cyc++) begin
      @(negedge clk);
      startIn = poke && (cyc == 6 || cyc == 9);
      lenIn   = (cyc == 6) ? LEN_W'(3) : LEN_W'(12);
      crcEnIn = !crc;
      outReady = stall ? (cyc % 3 != 1) : 1'b1;
      if (!pending) begin
        inValid = (srcIdx < len) && (gaps ? (cyc % 4 != 2) : 1'b1);
        inData  = srcByte(srcIdx, len);
      end
      #1;
      if (prevHeld && (!outValid || outData != prevData)) holdErr++;
      prevHeld = outValid && !outReady;
      prevData = outData;
      if (outValid && outReady) begin
        if (capN < 512) got[capN] = outData;
        capN++;
        lastCap = cyc;
      end
      if (inValid && inReady) begin srcIdx++; pending = 0; end
      else pending = inValid;
      if (doneOut) begin doneCnt++; doneCyc = cyc; end
      if (rejectOut) rejSeen++;
    end
    startIn = 1'b0; inValid = 1'b0; outReady = 1'b1; crcEnIn = 1'b0;
    check(capN == expN, {tag, " R4 byte count"}, capN, expN);
    for (int i = 0; i < expN && i < capN; i++)
      if (got[i] !== expB[i]) begin
        if (bad == 0)
          $display("  first mismatch at %0d: got %02h want %02h", i, got[i], expB[i]);
        bad++;
      end
    check(bad == 0, {tag, " stream content"}, bad, 0);
    check(srcIdx == len, {tag, " R6 bytes consumed"}, srcIdx, len);
    check(doneCnt == 1, {tag, " R8 done count"}, doneCnt, 1);
    check(doneCyc == lastCap + 1, {tag, " R8 done timing"}, doneCyc, lastCap + 1);
    if (stall) check(holdErr == 0, {tag, " R7 hold under stall"}, holdErr, 0);
    if (poke) check(rejSeen == 0, {tag, " R10 start ignored while busy"}, rejSeen, 0);
  endtask

  task automatic runReject(input int len);
    int noise = 0, rej = 0;
    @(negedge clk);
    startIn = 1'b1; lenIn = LEN_W'(len);
    @(negedge clk);
    startIn = 1'b0;
    #1;
    check(rejectOut == 1'b1, "R9 reject pulse", int'(rejectOut), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      #1;
      if (outValid || inReady) noise++;
      if (rejectOut) rej++;
    end
    inValid = 1'b0;
    check(noise == 0, "R9 no output after reject", noise, 0);
    check(rej == 0, "R9 reject is one cycle", rej, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!outValid && !inReady && !doneOut && !rejectOut, "R11 reset outputs",
          int'({outValid, inReady, doneOut, rejectOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(!outValid && !inReady && !doneOut && !rejectOut, "R11 idle after reset",
          int'({outValid, inReady, doneOut, rejectOut}), 0);
    runXfer(5,  0, 0, 0, 0, "R1 single packet");
    runXfer(8,  1, 0, 0, 0, "R1 R5 exact fit with trailer");
    runXfer(9,  0, 0, 0, 0, "R2 R3 two packets");
    runXfer(20, 1, 1, 1, 0, "R2 R3 R5 three packets stalled");
    runReject(4);
    runReject(0);
    runXfer(17, 0, 1, 0, 1, "R3 R10 start during transfer");
    runXfer(24, 1, 0, 1, 0, "R5 three full packets");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule